// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frames from a byte stream into memory through a ring of 8-byte descriptors. Each frame arrives as a header beat carrying its payload length and a precomputed 32-bit check sequence, followed by the payload bytes. Before any memory is touched, the engine walks the ring from its current pointer and confirms that enough consecutive empty descriptors exist to hold the payload plus the four check bytes. If there is not enough room, the frame is consumed and discarded.

A stored frame is split across buffers no larger than a programmable buffer size. The check bytes follow the payload and may straddle two buffers. Each used descriptor is written back with its length and with its empty bit cleared. The last descriptor also receives the last-in-frame bit and the status bits for over-length and truncation. The pointer then steps by eight bytes, or returns to the ring base when a descriptor carries the wrap bit.

Software enables the engine and arms reception through a small register port. Memory is reached through a simple request/grant port with 32-bit big-endian words and byte enables.

Top module: `rxbd_engine`

## Requirements
- R1: A descriptor is two big-endian words. The word at offset 0 holds flags in bits 31:16 and the length in bits 15:0, and the word at offset 4 holds the buffer address. Flag bit 15 means empty (owned by the engine), bit 13 means wrap and bit 11 means last in frame. The byte at address offset 0 of a word sits in bits 31:24, so a data byte write asserts exactly one byte enable.
- R2: The stored length is the payload length plus 4. The check-sequence bytes are stored most significant first, directly after the payload, even when they cross from one buffer into the next.
- R3: Each buffer receives at most the buffer-size value. Each used descriptor has bit 15 cleared, its other flag bits kept and its length field set to the byte count it received. The pointer then advances by 8, or loads the ring base if the wrap bit is set. A write to the ring-base register (address 3, low two bits forced to zero) also loads the pointer.
- R4: Only the final descriptor of a frame gets bit 11 and the status bits, and it raises a one-cycle `ev_frame` pulse. Each earlier descriptor raises a one-cycle `ev_buffer` pulse. The two pulses are never high together.
- R5: If payload plus 4 exceeds 2032, the frame is stored as 2028 payload bytes followed by the 4 check bytes. Status bits 0 (truncated) and 5 (over-length) are both set, and the leftover input bytes are consumed and discarded.
- R6: If the stored length exceeds bits 31:16 of the receive-control register (address 1), status bit 5 alone is set and the frame is still stored in full.
- R7: A frame is stored only if ceil(stored length / buffer size) consecutive empty descriptors start at the pointer. Otherwise the frame produces no memory write, a one-cycle `frame_drop` pulse and an unchanged pointer, and its bytes are consumed.
- R8: The buffer-size register (address 2) keeps only bits 10:4 of a write. A write whose bits 10:4 are all zero loads 0x7F0, and reset also loads 0x7F0.
- R9: A write to the demand register (address 4) while bit 0 of the control register (address 0) is set reads the descriptor at the pointer, and reception becomes active only if that descriptor is empty. After each stored frame the new pointer's descriptor is read again and decides whether reception stays active. Clearing the enable bit makes reception inactive within two cycles, and a demand write has no effect while the enable bit is clear.
- R10: Reading the demand register returns bit 24 set while reception is active, and zero otherwise.
- R11: The receive-control register resets to 0x05EE0001, and a write stores the written value ANDed with 0x07FF003F.
- R12: A frame header accepted while reception is inactive causes a one-cycle `frame_reject` pulse and no memory write, and the frame's bytes are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Registered read data, valid the cycle after the address |
| hdr_valid | input | 1 | Frame header offered |
| hdr_ready | output | 1 | Header accepted when both are high |
| hdr_len | input | 16 | Payload length in bytes |
| hdr_crc | input | 32 | Precomputed check sequence |
| dat_valid | input | 1 | Payload byte offered |
| dat_ready | output | 1 | Payload byte taken when both are high |
| dat_byte | input | 8 | Payload byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte enables, bit 3 is address offset 0 |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| ev_frame | output | 1 | Final descriptor of a frame written back |
| ev_buffer | output | 1 | Non-final descriptor written back |
| frame_reject | output | 1 | Frame refused because reception was inactive |
| frame_drop | output | 1 | Frame discarded because ring space was short |

## Verification
Two functions can fall in the same cycle: software clearing the enable bit while a frame is being written into buffers, and the engine's own post-frame re-read that decides whether reception stays active. The bench clears the enable bit partway through a multi-buffer frame, while the memory grant is stalled every fourth cycle. It then checks that the in-flight frame is still stored byte for byte with correct descriptors and events, that the demand register reads zero afterwards, and that the next frame is rejected. The ring-exhaustion case is handled in a similar way: a frame that needs exactly as many descriptors as are free must be stored, and the re-read must then leave reception inactive.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  // descriptor flag bit positions (within the 16-bit flag half-word)
  localparam int FL_EMPTY = 15;
  localparam int FL_WRAP  = 13;
  localparam int FL_LAST  = 11;
  localparam int FL_LONG  = 5;
  localparam int FL_TRUNC = 0;

  // register addresses
  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_RXCTL  = 3'd1;
  localparam logic [2:0] RA_BUFSZ  = 3'd2;
  localparam logic [2:0] RA_RING   = 3'd3;
  localparam logic [2:0] RA_DEMAND = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_PROBE, S_CHK, S_RD0, S_RD1, S_BYTE, S_WB, S_DRAIN
  } rx_state_t;
endpackage

// File: rtl/rxbd_regs.sv
module rxbd_regs
  import rxbd_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          BW       = 11,
  parameter logic [31:0] CTL_RST  = 32'h05EE_0001,
  parameter logic [31:0] CTL_MASK = 32'h07FF_003F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    waddr,
  input  logic [31:0]   wdata,
  input  logic [2:0]    raddr,
  input  logic          active,
  output logic [31:0]   rdata,
  output logic          en,
  output logic [15:0]   lim,
  output logic [BW-1:0] bufsz,
  output logic [AW-1:0] base,
  output logic          base_wr,
  output logic          demand_wr
);
  localparam logic [BW-1:0] BSZ_DEF = {{(BW-4){1'b1}}, 4'b0000};

  logic [31:0]   rxctl;
  logic [BW-5:0] fld;

  assign fld = wdata[BW-1:4];
  assign lim = rxctl[31:16];

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      rxctl     <= CTL_RST;
      bufsz     <= BSZ_DEF;
      base      <= '0;
      base_wr   <= 1'b0;
      demand_wr <= 1'b0;
      rdata     <= '0;
    end else begin
      base_wr   <= 1'b0;
      demand_wr <= 1'b0;
      if (we) begin
        case (waddr)
          RA_CTRL:   en    <= wdata[0];
          RA_RXCTL:  rxctl <= wdata & CTL_MASK;
          RA_BUFSZ:  bufsz <= (fld == '0) ? BSZ_DEF : {fld, 4'b0000};
          RA_RING: begin
            base    <= {wdata[AW-1:2], 2'b00};
            base_wr <= 1'b1;
          end
          RA_DEMAND: demand_wr <= 1'b1;
          default: ;
        endcase
      end
      case (raddr)
        RA_CTRL:   rdata <= {31'd0, en};
        RA_RXCTL:  rdata <= rxctl;
        RA_BUFSZ:  rdata <= 32'(bufsz);
        RA_RING:   rdata <= 32'(base);
        RA_DEMAND: rdata <= {7'd0, active, 24'd0};
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rxbd_sizer.sv
module rxbd_sizer #(
  parameter int LW   = 16,
  parameter int MAXF = 2032
) (
  input  logic [LW-1:0] flen,
  input  logic [15:0]   lim,
  output logic [LW-1:0] slen,
  output logic          trunc,
  output logic          long_f,
  output logic [LW-1:0] excess
);
  logic [LW:0] raw;

  always_comb begin
    raw    = {1'b0, flen} + (LW+1)'(4);
    trunc  = raw > (LW+1)'(MAXF);
    slen   = trunc ? LW'(MAXF) : raw[LW-1:0];
    long_f = trunc | (32'(slen) > 32'(lim));
    excess = trunc ? (flen - LW'(MAXF - 4)) : '0;
  end
endmodule

// File: rtl/rxbd_fsm.sv
module rxbd_fsm
  import rxbd_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int BW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [BW-1:0] bufsz,
  input  logic [AW-1:0] base,
  input  logic          base_wr,
  input  logic          demand_wr,
  input  logic          hdr_valid,
  output logic          hdr_ready,
  input  logic [LW-1:0] hdr_len,
  input  logic [31:0]   hdr_crc,
  input  logic [LW-1:0] sz_slen,
  input  logic          sz_trunc,
  input  logic          sz_long,
  input  logic [LW-1:0] sz_excess,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [7:0]    dat_byte,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          active,
  output logic          ev_frame,
  output logic          ev_buffer,
  output logic          reject,
  output logic          drop
);
  rx_state_t     st;
  logic [AW-1:0] ptr, chk_addr, buf_addr;
  logic          pend, post_probe, tr_q, lg_q;
  logic [LW-1:0] slen_q, flen_q, excess_q, rem, off, chunk_left, chunk_len;
  logic [LW-1:0] chk_rem, drain_cnt;
  logic [31:0]   crc_q;
  logic [15:0]   cur_flags, new_flags;

  logic [LW-1:0] bsz_ext, pay_n, crc_off, next_chunk;
  logic          is_pay;
  logic [7:0]    crc_b, wbyte;
  logic [1:0]    crc_idx;

  always_comb begin
    bsz_ext    = LW'(bufsz);
    pay_n      = slen_q - LW'(4);
    is_pay     = off < pay_n;
    crc_off    = off - pay_n;
    crc_idx    = crc_off[1:0];
    crc_b      = 8'(crc_q >> {2'd3 - crc_idx, 3'b000});
    wbyte      = is_pay ? dat_byte : crc_b;
    next_chunk = (rem < bsz_ext) ? rem : bsz_ext;
    new_flags  = cur_flags;
    new_flags[FL_EMPTY] = 1'b0;
    if (rem == '0) begin
      new_flags[FL_LAST]  = 1'b1;
      new_flags[FL_LONG]  = new_flags[FL_LONG] | lg_q;
      new_flags[FL_TRUNC] = new_flags[FL_TRUNC] | tr_q;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_be    = 4'hF;
    mem_wdata = '0;
    case (st)
      S_PROBE, S_RD0: mem_req = 1'b1;
      S_CHK: begin
        mem_req  = 1'b1;
        mem_addr = chk_addr;
      end
      S_RD1: begin
        mem_req  = 1'b1;
        mem_addr = ptr + AW'(4);
      end
      S_BYTE: begin
        mem_req   = is_pay ? dat_valid : 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_addr;
        mem_be    = 4'b1000 >> buf_addr[1:0];
        mem_wdata = {4{wbyte}};
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {new_flags, 16'(chunk_len)};
      end
      default: ;
    endcase
    hdr_ready = (st == S_IDLE) && !pend;
    dat_ready = ((st == S_BYTE) && is_pay && mem_gnt) || (st == S_DRAIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ptr        <= '0;
      chk_addr   <= '0;
      buf_addr   <= '0;
      pend       <= 1'b0;
      post_probe <= 1'b0;
      tr_q       <= 1'b0;
      lg_q       <= 1'b0;
      slen_q     <= '0;
      flen_q     <= '0;
      excess_q   <= '0;
      rem        <= '0;
      off        <= '0;
      chunk_left <= '0;
      chunk_len  <= '0;
      chk_rem    <= '0;
      drain_cnt  <= '0;
      crc_q      <= '0;
      cur_flags  <= '0;
      active     <= 1'b0;
      ev_frame   <= 1'b0;
      ev_buffer  <= 1'b0;
      reject     <= 1'b0;
      drop       <= 1'b0;
    end else begin
      ev_frame  <= 1'b0;
      ev_buffer <= 1'b0;
      reject    <= 1'b0;
      drop      <= 1'b0;
      case (st)
        S_IDLE: begin
          if (pend) begin
            pend <= 1'b0;
            st   <= S_PROBE;
          end else if (hdr_valid) begin
            flen_q   <= hdr_len;
            crc_q    <= hdr_crc;
            slen_q   <= sz_slen;
            tr_q     <= sz_trunc;
            lg_q     <= sz_long;
            excess_q <= sz_excess;
            if (!active) begin
              reject     <= 1'b1;
              drain_cnt  <= hdr_len;
              post_probe <= 1'b0;
              st         <= (hdr_len == '0) ? S_IDLE : S_DRAIN;
            end else begin
              chk_addr <= ptr;
              chk_rem  <= sz_slen;
              st       <= S_CHK;
            end
          end
        end
        S_PROBE: if (mem_gnt) begin
          active <= mem_rdata[16+FL_EMPTY];
          st     <= S_IDLE;
        end
        S_CHK: if (mem_gnt) begin
          if (!mem_rdata[16+FL_EMPTY]) begin
            drop       <= 1'b1;
            drain_cnt  <= flen_q;
            post_probe <= 1'b0;
            st         <= (flen_q == '0) ? S_IDLE : S_DRAIN;
          end else if (chk_rem <= bsz_ext) begin
            rem <= slen_q;
            off <= '0;
            st  <= S_RD0;
          end else begin
            chk_rem  <= chk_rem - bsz_ext;
            chk_addr <= mem_rdata[16+FL_WRAP] ? base : chk_addr + AW'(8);
          end
        end
        S_RD0: if (mem_gnt) begin
          cur_flags  <= mem_rdata[31:16];
          chunk_len  <= next_chunk;
          chunk_left <= next_chunk;
          st         <= S_RD1;
        end
        S_RD1: if (mem_gnt) begin
          buf_addr <= mem_rdata[AW-1:0];
          st       <= S_BYTE;
        end
        S_BYTE: if (mem_req && mem_gnt) begin
          buf_addr   <= buf_addr + AW'(1);
          off        <= off + LW'(1);
          rem        <= rem - LW'(1);
          chunk_left <= chunk_left - LW'(1);
          if (chunk_left == LW'(1)) st <= S_WB;
        end
        S_WB: if (mem_gnt) begin
          if (rem == '0) ev_frame <= 1'b1;
          else           ev_buffer <= 1'b1;
          ptr <= cur_flags[FL_WRAP] ? base : ptr + AW'(8);
          if (rem != '0) st <= S_RD0;
          else if (excess_q != '0) begin
            drain_cnt  <= excess_q;
            post_probe <= 1'b1;
            st         <= S_DRAIN;
          end else st <= S_PROBE;
        end
        S_DRAIN: if (dat_valid) begin
          drain_cnt <= drain_cnt - LW'(1);
          if (drain_cnt == LW'(1)) st <= post_probe ? S_PROBE : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (base_wr) ptr <= base;
      if (!en) begin
        active <= 1'b0;
        pend   <= 1'b0;
      end else if (demand_wr && !active) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
  import rxbd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int BW   = 11,
  parameter int MAXF = 2032
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [2:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [2:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  input  logic        hdr_valid,
  output logic        hdr_ready,
  input  logic [15:0] hdr_len,
  input  logic [31:0] hdr_crc,
  input  logic        dat_valid,
  output logic        dat_ready,
  input  logic [7:0]  dat_byte,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  output logic        ev_frame,
  output logic        ev_buffer,
  output logic        frame_reject,
  output logic        frame_drop
);
  logic          en, base_wr, demand_wr, rx_active;
  logic [15:0]   lim;
  logic [BW-1:0] buf_size;
  logic [AW-1:0] base, addr_w;
  logic [LW-1:0] slen, excess, flen;
  logic          trunc, long_f;

  assign flen     = LW'(hdr_len);
  assign mem_addr = 32'(addr_w);

  rxbd_regs #(.AW(AW), .BW(BW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .active(rx_active), .rdata(reg_rdata), .en(en),
    .lim(lim), .bufsz(buf_size), .base(base), .base_wr(base_wr),
    .demand_wr(demand_wr)
  );

  rxbd_sizer #(.LW(LW), .MAXF(MAXF)) u_sizer (
    .flen(flen), .lim(lim), .slen(slen), .trunc(trunc), .long_f(long_f),
    .excess(excess)
  );

  rxbd_fsm #(.AW(AW), .LW(LW), .BW(BW)) u_fsm (
    .clk(clk), .rst(rst), .en(en), .bufsz(buf_size), .base(base),
    .base_wr(base_wr), .demand_wr(demand_wr),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_len(flen),
    .hdr_crc(hdr_crc), .sz_slen(slen), .sz_trunc(trunc), .sz_long(long_f),
    .sz_excess(excess), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_byte(dat_byte), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(addr_w), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .active(rx_active),
    .ev_frame(ev_frame), .ev_buffer(ev_buffer), .reject(frame_reject),
    .drop(frame_drop)
  );
endmodule

// File: rtl/rxbd_checker.sv
module rxbd_checker
  import rxbd_pkg::*;
#(
  parameter int BW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          ev_frame,
  input logic          ev_buffer,
  input logic          frame_reject,
  input logic          hdr_valid,
  input logic          hdr_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [31:0]   mem_addr,
  input logic [3:0]    mem_be,
  input logic          reg_we,
  input logic [2:0]    reg_waddr,
  input logic [31:0]   reg_wdata,
  input logic          rx_active,
  input logic [BW-1:0] buf_size
);
  a_r4_evt_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ev_frame && ev_buffer));

  a_r12_reject_needs_hdr: assert property (@(posedge clk) disable iff (rst)
    frame_reject |-> $past(hdr_valid && hdr_ready));

  a_r1_single_lane: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

  a_r9_disable_drops_active: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_waddr == RA_CTRL && !reg_wdata[0]) |=> ##1 !rx_active);

  a_r8_bufsz_legal: assert property (@(posedge clk) disable iff (rst)
    (buf_size != '0) && (buf_size[3:0] == 4'd0));

  a_r7_read_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
endmodule

bind rxbd_engine rxbd_checker #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .ev_frame(ev_frame), .ev_buffer(ev_buffer),
  .frame_reject(frame_reject), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
  .mem_be(mem_be), .reg_we(reg_we), .reg_waddr(reg_waddr),
  .reg_wdata(reg_wdata), .rx_active(rx_active), .buf_size(buf_size)
);

// File: tb/rxbd_engine_tb.sv
`timescale 1ns/1ps
module rxbd_engine_tb_top;
  localparam int RING = 32'h100;
  localparam int ND   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        hdr_valid = 1'b0, hdr_ready;
  logic [15:0] hdr_len = '0;
  logic [31:0] hdr_crc = '0;
  logic        dat_valid = 1'b0, dat_ready;
  logic [7:0]  dat_byte = '0;
  logic        mem_req, mem_we, mem_gnt = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        ev_frame, ev_buffer, frame_reject, frame_drop;

  logic [31:0] mem [0:8191];
  int total = 0, bad = 0, cyc = 0, gcnt = 0;
  int n_rxf = 0, n_rxb = 0, n_rej = 0, n_drop = 0;
  int bptr = 0;

  always #2.5 clk = ~clk;

  rxbd_engine dut_i (.*);

  assign mem_rdata = mem[mem_addr[14:2]];

  always @(posedge clk)
    if (mem_req && mem_we && mem_gnt)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[14:2]][8*b +: 8] <= mem_wdata[8*b +: 8];

  always @(negedge clk) begin
    gcnt++;
    mem_gnt <= (gcnt % 4) != 3;
    if (!rst) begin
      if (ev_frame) n_rxf++;
      if (ev_buffer) n_rxb++;
      if (frame_reject) n_rej++;
      if (frame_drop) n_drop++;
    end
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_raddr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!hdr_ready) @(negedge clk);
  endtask

  function automatic int buf_of(input int i);
    return 32'h1000 + i * 32'h800;
  endfunction

  function automatic logic [7:0] rdb(input int a);
    return 8'(mem[a >> 2] >> (8 * (3 - (a & 3))));
  endfunction

  task automatic arm_all();
    for (int i = 0; i < ND; i++) begin
      mem[(RING + 8*i) >> 2]     = {(i == ND-1) ? 16'hA000 : 16'h8000, 16'h0};
      mem[(RING + 8*i + 4) >> 2] = buf_of(i);
    end
  endtask

  task automatic send_frame(input int plen, input logic [31:0] crc, input int seed);
    @(negedge clk); hdr_valid = 1'b1; hdr_len = 16'(plen); hdr_crc = crc;
    forever begin #1; if (hdr_ready) break; @(negedge clk); end
    @(negedge clk); hdr_valid = 1'b0;
    for (int i = 0; i < plen; i++) begin
      if (i % 7 == 6) begin dat_valid = 1'b0; @(negedge clk); end
      dat_valid = 1'b1; dat_byte = 8'(seed + i);
      forever begin #1; if (dat_ready) break; @(negedge clk); end
      @(negedge clk);
    end
    dat_valid = 1'b0;
  endtask

  // checks descriptors, data and events for a stored frame (R1-R6)
  task automatic check_frame(input int plen, input logic [31:0] crc, input int seed,
                             input int mbs, input int lim, input int f0, input int b0);
    int slen, rem, nd, idx, g, errs, ln;
    bit tr, lg, last;
    logic [15:0] fl;
    logic [7:0] e;
    slen = plen + 4; tr = slen > 2032; if (tr) slen = 2032;
    lg = tr || (slen > lim);
    nd = (slen + mbs - 1) / mbs;
    rem = slen; g = 0; errs = 0;
    for (int d = 0; d < nd; d++) begin
      idx = (bptr + d) % ND;
      ln = (rem < mbs) ? rem : mbs;
      rem -= ln; last = (rem == 0);
      fl = (idx == ND-1) ? 16'h2000 : 16'h0;
      if (last) fl = fl | 16'h0800 | (lg ? 16'h0020 : 16'h0) | (tr ? 16'h0001 : 16'h0);
      chk(mem[(RING + 8*idx) >> 2] == {fl, 16'(ln)}, "R1 R3 R4 R5 R6 descriptor word",
          mem[(RING + 8*idx) >> 2], {fl, 16'(ln)});
      for (int k = 0; k < ln; k++) begin
        if (g < slen - 4) e = 8'(seed + g);
        else e = 8'(crc >> (8 * (3 - (g - (slen - 4)))));
        if (rdb(buf_of(idx) + k) != e) errs++;
        g++;
      end
    end
    chk(errs == 0, "R2 R5 stored bytes", errs, 0);
    chk(n_rxf - f0 == 1, "R4 frame event", n_rxf - f0, 1);
    chk(n_rxb - b0 == nd - 1, "R4 buffer events", n_rxb - b0, nd - 1);
    bptr = (bptr + nd) % ND;
  endtask

  task automatic run_frame(input int plen, input logic [31:0] crc, input int seed,
                           input int mbs, input int lim);
    int f0, b0;
    f0 = n_rxf; b0 = n_rxb;
    send_frame(plen, crc, seed);
    wait_idle();
    check_frame(plen, crc, seed, mbs, lim, f0, b0);
  endtask

  initial begin
    logic [31:0] v;
    int f0, b0, r0, d0;
    for (int i = 0; i < 8192; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    rd_reg(3'd1, v); chk(v == 32'h05EE_0001, "R11 reset", v, 32'h05EE_0001);
    rd_reg(3'd2, v); chk(v == 32'h7F0, "R8 reset", v, 32'h7F0);
    rd_reg(3'd4, v); chk(v == 32'h0, "R10 reset inactive", v, 0);
    wr_reg(3'd1, 32'hFFFF_FFFF);
    rd_reg(3'd1, v); chk(v == 32'h07FF_003F, "R11 mask", v, 32'h07FF_003F);
    wr_reg(3'd1, 32'h05EE_0001);
    wr_reg(3'd2, 32'h0);      rd_reg(3'd2, v); chk(v == 32'h7F0, "R8 zero", v, 32'h7F0);
    wr_reg(3'd2, 32'h123F);   rd_reg(3'd2, v); chk(v == 32'h230, "R8 mask", v, 32'h230);
    wr_reg(3'd2, 32'h5);      rd_reg(3'd2, v); chk(v == 32'h7F0, "R8 low bits only", v, 32'h7F0);
    wr_reg(3'd2, 32'h10);

    // R12: frame while inactive
    arm_all();
    wr_reg(3'd3, RING + 3);
    rd_reg(3'd3, v); chk(v == RING, "R3 ring base", v, RING);
    wr_reg(3'd0, 32'h1);
    r0 = n_rej;
    send_frame(5, 32'h1234_5678, 9); wait_idle();
    chk(n_rej - r0 == 1, "R12 reject pulse", n_rej - r0, 1);
    chk(mem[RING >> 2] == 32'h8000_0000, "R12 no write", mem[RING >> 2], 32'h8000_0000);
    wr_reg(3'd0, 32'h0); wr_reg(3'd4, 32'h0); wait_idle();
    rd_reg(3'd4, v); chk(v == 32'h0, "R9 demand ignored when disabled", v, 0);
    wr_reg(3'd0, 32'h1); wr_reg(3'd4, 32'h0); wait_idle();
    rd_reg(3'd4, v); chk(v == 32'h0100_0000, "R9 R10 activate", v, 32'h0100_0000);

    // sweep of lengths with 16-byte buffers (R1-R4)
    for (int p = 0; p <= 40; p++) begin
      arm_all();
      run_frame(p, 32'hC0DE_0000 + p, 3 * p, 16, 32'h5EE);
    end

    // R7: space check
    arm_all();
    mem[(RING + 8*((bptr + 2) % ND)) >> 2] = 32'h0;
    d0 = n_drop; f0 = n_rxf;
    send_frame(40, 32'hDEAD_BEEF, 1); wait_idle();
    chk(n_drop - d0 == 1, "R7 drop pulse", n_drop - d0, 1);
    chk(n_rxf == f0, "R7 no event", n_rxf - f0, 0);
    chk(mem[(RING + 8*bptr) >> 2][31:16] != 16'h0 && mem[(RING + 8*bptr) >> 2][15:0] == 16'h0,
        "R7 descriptor untouched", mem[(RING + 8*bptr) >> 2], 0);
    run_frame(28, 32'hA1B2_C3D4, 77, 16, 32'h5EE);
    rd_reg(3'd4, v); chk(v == 32'h0, "R9 reprobe finds full", v, 0);

    // R6 with a small limit, multi-buffer
    arm_all(); wr_reg(3'd4, 32'h0); wait_idle();
    rd_reg(3'd4, v); chk(v == 32'h0100_0000, "R9 reactivate", v, 32'h0100_0000);
    wr_reg(3'd1, 32'h0040_0001);
    run_frame(60, 32'h0BAD_F00D, 5, 16, 64);
    arm_all();
    run_frame(61, 32'h0BAD_F00E, 6, 16, 64);
    wr_reg(3'd1, 32'h05EE_0001);

    // R5: truncation with one large buffer, then a follow-up frame
    wr_reg(3'd2, 32'h7F0);
    arm_all();
    run_frame(2040, 32'h8765_4321, 11, 2032, 32'h5EE);
    arm_all();
    run_frame(3, 32'h1122_3344, 200, 2032, 32'h5EE);
    wr_reg(3'd2, 32'h10);

    // enable cleared while a frame is being stored (R9, R12)
    arm_all();
    f0 = n_rxf; b0 = n_rxb;
    fork
      send_frame(40, 32'hFACE_CAFE, 40);
      begin repeat (18) @(negedge clk); wr_reg(3'd0, 32'h0); end
    join
    wait_idle();
    check_frame(40, 32'hFACE_CAFE, 40, 16, 32'h5EE, f0, b0);
    rd_reg(3'd4, v); chk(v == 32'h0, "R9 disabled after frame", v, 0);
    r0 = n_rej;
    send_frame(4, 32'h0, 0); wait_idle();
    chk(n_rej - r0 == 1, "R12 reject after disable", n_rej - r0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule